// File: doc/BRIEF.md
# Host Command Dispatcher with Console

This block sits between a processor's to-host mailbox and the simulation harness. Each 64-bit request word is split into a device number (bits 63:56), a command (bits 55:48) and a 48-bit payload (bits 47:0). The block then takes one of several actions:

- It raises a sticky exit indication carrying a pass/fail code.
- It sends one console character over a valid/ready output stream.
- It parks a console read until a character arrives on the input stream.
- It flags a system-call pointer as unsupported.
- It answers unknown requests with an empty result.

Every request produces exactly one 64-bit response word, announced by a one-cycle load strobe, for the from-host register. The response carries the request's device and command byte pair in bits 63:48 above a 16-bit result in bits 15:0.

Back-pressure rules are as follows. A request is taken on any clock edge where `req_valid` is high and `busy` is low. Requests offered while `busy` is high are not taken and have no effect. The transmit stream follows valid/ready: `tx_valid` and `tx_data` stay steady until the edge where `tx_ready` is high. The receive stream has no ready signal. A byte that arrives while no read is parked is discarded.

Top module: `host_cmd_dispatch`

## Requirements
- R1: Every response word repeats request bits 63:48 in bits 63:48, has bits 47:16 zero, and holds the result in bits 15:0.
- R2: Device 0, command 0 with payload bit 0 set is an exit. One cycle after acceptance, `exit_valid` is high, `exit_code` equals payload bits 47:1, and a response with result 0 is loaded.
- R3: Once high, `exit_valid` stays high until reset. `exit_code` keeps the first code; later exit requests leave it unchanged.
- R4: Device 0, command 0 with payload bit 0 clear is a system-call pointer. One cycle after acceptance, `unsupported` pulses high for one cycle together with a response whose result is 0.
- R5: Device 1, command 1 raises `tx_valid` with `tx_data` equal to payload bits 7:0 in the cycle after acceptance. Both hold until a cycle in which `tx_ready` is high. In the cycle after that handshake, a response with result 0x100 ORed with the byte is loaded.
- R6: Device 1, command 0 parks a read. In the cycle after the first edge on which `rx_valid` is high, a response is loaded. Its result is 0x100 ORed with `rx_data`, and its bits 63:48 come from the parked request.
- R7: A device other than 0 or 1, device 0 with a nonzero command, or device 1 with a command above 1 gives a response with result 0, one cycle after acceptance.
- R8: An `rx_valid` byte seen while no read is parked causes no response and is not kept for a later read.
- R9: `busy` is high exactly while a write awaits its handshake or a read is parked. Requests offered then are ignored. `resp_load` is a single-cycle pulse per request.
- R10: During and just after reset, `busy`, `tx_valid`, `resp_load`, `exit_valid` and `unsupported` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word present |
| req_word | input | 64 | Request: device, command, payload |
| busy | output | 1 | Request not accepted this cycle |
| tx_valid | output | 1 | Console output byte present |
| tx_ready | input | 1 | Console sink takes the byte |
| tx_data | output | 8 | Console output byte |
| rx_valid | input | 1 | Console input byte present (no back-pressure) |
| rx_data | input | 8 | Console input byte |
| exit_valid | output | 1 | Sticky exit indication |
| exit_code | output | 47 | Exit code, zero meaning pass |
| unsupported | output | 1 | One-cycle flag for a system-call pointer |
| resp_load | output | 1 | One-cycle strobe for the response word |
| resp_word | output | 64 | Response for the from-host register |

## Verification
The hardest situations to reach are the ones where the block is waiting: a write stalled by a low `tx_ready`, or a read parked with no input byte. During those waits a new request or a stray byte must leave no trace. The bench holds `tx_ready` low for several cycles and offers an extra request during the stall. It also pushes an input byte while idle, before any read is parked. It then confirms that the next response carries only the parked request's tag and the byte delivered later.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  typedef enum logic [2:0] {
    K_EXIT,
    K_SYSPTR,
    K_PUTC,
    K_GETC,
    K_BAD
  } req_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ
  } disp_state_t;

  localparam int DEV_SYS  = 0;
  localparam int DEV_CON  = 1;
  localparam int CMD_CALL = 0;
  localparam int CMD_GET  = 0;
  localparam int CMD_PUT  = 1;
endpackage

// File: rtl/hcd_decode.sv
module hcd_decode
  import hcd_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int FIELD_W = 8
) (
  input  logic [WORD_W-1:0]          req_word,
  output req_kind_t                  kind,
  output logic [2*FIELD_W-1:0]       tag,
  output logic [WORD_W-2*FIELD_W-1:0] payload
);
  localparam int PAY_W = WORD_W - 2*FIELD_W;

  logic [FIELD_W-1:0] dev;
  logic [FIELD_W-1:0] cmd;

  assign dev     = req_word[WORD_W-1 -: FIELD_W];
  assign cmd     = req_word[PAY_W +: FIELD_W];
  assign tag     = req_word[WORD_W-1 -: 2*FIELD_W];
  assign payload = req_word[PAY_W-1:0];

  always_comb begin
    kind = K_BAD;
    if (dev == FIELD_W'(DEV_SYS)) begin
      if (cmd == FIELD_W'(CMD_CALL)) kind = payload[0] ? K_EXIT : K_SYSPTR;
    end else if (dev == FIELD_W'(DEV_CON)) begin
      if (cmd == FIELD_W'(CMD_GET))      kind = K_GETC;
      else if (cmd == FIELD_W'(CMD_PUT)) kind = K_PUTC;
    end
  end
endmodule

// File: rtl/hcd_resp_fmt.sv
module hcd_resp_fmt #(
  parameter int WORD_W   = 64,
  parameter int FIELD_W  = 8,
  parameter int RESULT_W = 16
) (
  input  logic [2*FIELD_W-1:0] tag,
  input  logic [RESULT_W-1:0]  result,
  output logic [WORD_W-1:0]    word
);
  localparam int GAP_W = WORD_W - 2*FIELD_W - RESULT_W;

  assign word = {tag, {GAP_W{1'b0}}, result};
endmodule

// File: rtl/hcd_exit_hold.sv
module hcd_exit_hold #(
  parameter int CODE_W = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [CODE_W-1:0] code_in,
  output logic              valid,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
    end else if (set && !valid) begin
      valid <= 1'b1;
      code  <= code_in;
    end
  end
endmodule

// File: rtl/host_cmd_dispatch.sv
module host_cmd_dispatch
  import hcd_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int FIELD_W  = 8,
  parameter int RESULT_W = 16,
  parameter int CHAR_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  input  logic [WORD_W-1:0]               req_word,
  output logic                            busy,
  output logic                            tx_valid,
  input  logic                            tx_ready,
  output logic [CHAR_W-1:0]               tx_data,
  input  logic                            rx_valid,
  input  logic [CHAR_W-1:0]               rx_data,
  output logic                            exit_valid,
  output logic [WORD_W-2*FIELD_W-2:0]     exit_code,
  output logic                            unsupported,
  output logic                            resp_load,
  output logic [WORD_W-1:0]               resp_word
);
  localparam int PAY_W  = WORD_W - 2*FIELD_W;
  localparam int TAG_W  = 2*FIELD_W;
  localparam int CODE_W = PAY_W - 1;
  localparam logic [RESULT_W-1:0] ACK_FLAG = RESULT_W'(1) << CHAR_W;

  req_kind_t          kind;
  logic [TAG_W-1:0]   req_tag;
  logic [PAY_W-1:0]   payload;

  disp_state_t        state_q, state_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic [CHAR_W-1:0]  char_q, char_d;

  logic               accept;
  logic               fire;
  logic               unsup_fire;
  logic               exit_set;
  logic [TAG_W-1:0]   fmt_tag;
  logic [RESULT_W-1:0] fmt_result;
  logic [WORD_W-1:0]  fmt_word;

  hcd_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_decode (
    .req_word (req_word),
    .kind     (kind),
    .tag      (req_tag),
    .payload  (payload)
  );

  hcd_resp_fmt #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .RESULT_W(RESULT_W)) u_fmt (
    .tag    (fmt_tag),
    .result (fmt_result),
    .word   (fmt_word)
  );

  hcd_exit_hold #(.CODE_W(CODE_W)) u_exit (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (exit_set),
    .code_in (payload[PAY_W-1:1]),
    .valid   (exit_valid),
    .code    (exit_code)
  );

  assign busy     = (state_q != ST_IDLE);
  assign accept   = req_valid && !busy;
  assign tx_valid = (state_q == ST_WRITE);
  assign tx_data  = char_q;

  always_comb begin
    state_d    = state_q;
    tag_d      = tag_q;
    char_d     = char_q;
    fire       = 1'b0;
    unsup_fire = 1'b0;
    exit_set   = 1'b0;
    fmt_tag    = tag_q;
    fmt_result = '0;
    unique case (state_q)
      ST_IDLE: begin
        fmt_tag = req_tag;
        if (accept) begin
          unique case (kind)
            K_EXIT:   begin fire = 1'b1; exit_set = 1'b1; end
            K_SYSPTR: begin fire = 1'b1; unsup_fire = 1'b1; end
            K_PUTC: begin
              state_d = ST_WRITE;
              tag_d   = req_tag;
              char_d  = payload[CHAR_W-1:0];
            end
            K_GETC: begin
              state_d = ST_READ;
              tag_d   = req_tag;
            end
            default:  fire = 1'b1;
          endcase
        end
      end
      ST_WRITE: begin
        fmt_result = ACK_FLAG | RESULT_W'(char_q);
        if (tx_ready) begin
          fire    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_READ: begin
        fmt_result = ACK_FLAG | RESULT_W'(rx_data);
        if (rx_valid) begin
          fire    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      char_q      <= '0;
      resp_load   <= 1'b0;
      resp_word   <= '0;
      unsupported <= 1'b0;
    end else begin
      state_q     <= state_d;
      tag_q       <= tag_d;
      char_q      <= char_d;
      resp_load   <= fire;
      unsupported <= unsup_fire;
      if (fire) resp_word <= fmt_word;
    end
  end
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker #(
  parameter int WORD_W   = 64,
  parameter int FIELD_W  = 8,
  parameter int RESULT_W = 16,
  parameter int CHAR_W   = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        busy,
  input logic                        tx_valid,
  input logic                        tx_ready,
  input logic [CHAR_W-1:0]           tx_data,
  input logic                        exit_valid,
  input logic [WORD_W-2*FIELD_W-2:0] exit_code,
  input logic                        unsupported,
  input logic                        resp_load,
  input logic [WORD_W-1:0]           resp_word
);
  localparam int PAY_W = WORD_W - 2*FIELD_W;

  assert_gap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    resp_load |-> resp_word[PAY_W-1:RESULT_W] == '0);

  assert_exit_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exit_valid |=> exit_valid && $stable(exit_code));

  assert_unsup_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> resp_load && resp_word[RESULT_W-1:0] == '0);

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> resp_load && resp_word[CHAR_W] &&
      resp_word[CHAR_W-1:0] == $past(tx_data));

  assert_tx_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);
endmodule

bind host_cmd_dispatch hcd_checker #(
  .WORD_W(WORD_W), .FIELD_W(FIELD_W), .RESULT_W(RESULT_W), .CHAR_W(CHAR_W)
) u_hcd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data),
  .exit_valid  (exit_valid),
  .exit_code   (exit_code),
  .unsupported (unsupported),
  .resp_load   (resp_load),
  .resp_word   (resp_word)
);

// File: tb/test_host_cmd_dispatch.sv
module test_host_cmd_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_word = '0;
  logic        busy;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        exit_valid;
  logic [46:0] exit_code;
  logic        unsupported;
  logic        resp_load;
  logic [63:0] resp_word;

  int checks = 0;
  int errors = 0;
  bit exit_seen = 1'b0;
  logic [46:0] exit_exp = '0;

  always #4 clk = ~clk;

  host_cmd_dispatch i_host_cmd_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
    .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .exit_valid(exit_valid),
    .exit_code(exit_code), .unsupported(unsupported), .resp_load(resp_load),
    .resp_word(resp_word)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rsp(input logic [15:0] tag, input logic [15:0] res);
    return {tag, 32'h0, res};
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 busy", 64'(busy), 0);
    chk(tx_valid == 0, "R10 tx_valid", 64'(tx_valid), 0);
    chk(resp_load == 0, "R10 resp_load", 64'(resp_load), 0);
    chk(exit_valid == 0, "R10 exit_valid", 64'(exit_valid), 0);
    chk(unsupported == 0, "R10 unsupported", 64'(unsupported), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 stray byte while idle is dropped
    rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(resp_load == 0, "R8 no response", 64'(resp_load), 0);
    chk(busy == 0, "R8 stays idle", 64'(busy), 0);
    @(negedge clk);
    chk(resp_load == 0, "R8 no late response", 64'(resp_load), 0);

    for (int dev = 0; dev < 4; dev++) begin
      for (int cmd = 0; cmd < 4; cmd++) begin
        for (int b = 0; b < 2; b++) begin
          logic [47:0] p;
          logic [15:0] tag;
          logic [7:0]  rb;
          p   = 48'h00A5_3C00_0000 | (48'(dev) << 20) | (48'(cmd) << 16)
                | 48'(8'h92 + b);
          tag = {8'(dev), 8'(cmd)};
          req_valid = 1'b1; req_word = {tag, p};
          @(negedge clk);
          req_valid = 1'b0;
          if (dev == 1 && cmd == 1) begin
            chk(tx_valid == 1, "R5 tx_valid", 64'(tx_valid), 1);
            chk(tx_data == p[7:0], "R5 tx_data", 64'(tx_data), 64'(p[7:0]));
            chk(busy == 1, "R9 busy on write", 64'(busy), 1);
            req_valid = 1'b1; req_word = 64'h0300_0000_0000_0001;
            repeat (2) begin
              @(negedge clk);
              chk(resp_load == 0, "R9 stalled write no resp", 64'(resp_load), 0);
              chk(tx_valid == 1 && tx_data == p[7:0], "R5 hold", 64'(tx_data), 64'(p[7:0]));
            end
            req_valid = 1'b0;
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
            chk(resp_load == 1, "R5 ack load", 64'(resp_load), 1);
            chk(resp_word == rsp(tag, {8'h01, p[7:0]}), "R5 ack word",
                resp_word, rsp(tag, {8'h01, p[7:0]}));
            chk(busy == 0 && tx_valid == 0, "R9 idle after write", 64'(busy), 0);
          end else if (dev == 1 && cmd == 0) begin
            chk(busy == 1, "R9 busy on read", 64'(busy), 1);
            req_valid = 1'b1; req_word = 64'h0101_0000_0000_0041;
            repeat (2) begin
              @(negedge clk);
              chk(resp_load == 0 && tx_valid == 0, "R9 parked read ignores req",
                  64'(resp_load), 0);
            end
            req_valid = 1'b0;
            rb = 8'hC0 ^ 8'(b * 8'h3D);
            rx_valid = 1'b1; rx_data = rb;
            @(negedge clk);
            rx_valid = 1'b0;
            chk(resp_load == 1, "R6 read load", 64'(resp_load), 1);
            chk(resp_word == rsp(tag, {8'h01, rb}), "R6 read word",
                resp_word, rsp(tag, {8'h01, rb}));
            chk(busy == 0, "R9 idle after read", 64'(busy), 0);
          end else begin
            chk(resp_load == 1, "R7 immediate load", 64'(resp_load), 1);
            chk(resp_word == rsp(tag, 16'h0), "R1 R7 zero result word",
                resp_word, rsp(tag, 16'h0));
            chk(unsupported == (dev == 0 && cmd == 0 && b == 0), "R4 unsupported",
                64'(unsupported), 64'(dev == 0 && cmd == 0 && b == 0));
            if (dev == 0 && cmd == 0 && b == 1 && !exit_seen) begin
              exit_seen = 1'b1;
              exit_exp  = p[47:1];
            end
            chk(exit_valid == exit_seen, "R2 exit_valid", 64'(exit_valid), 64'(exit_seen));
            if (exit_seen)
              chk(exit_code == exit_exp, "R2 exit_code", 64'(exit_code), 64'(exit_exp));
          end
          @(negedge clk);
          chk(resp_load == 0 && unsupported == 0, "R9 single pulse", 64'(resp_load), 0);
        end
      end
    end

    // R3 a second exit leaves the first code in place
    req_valid = 1'b1; req_word = 64'h0000_0000_0000_00FF;
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_word == rsp(16'h0000, 16'h0), "R2 exit response", resp_word, 0);
    repeat (3) @(negedge clk);
    chk(exit_valid == 1, "R3 exit held", 64'(exit_valid), 1);
    chk(exit_code == exit_exp, "R3 code kept", 64'(exit_code), 64'(exit_exp));

    // R8 stray byte not kept for the next read
    rx_valid = 1'b1; rx_data = 8'h5E;
    @(negedge clk);
    rx_valid = 1'b0;
    req_valid = 1'b1; req_word = 64'h0100_ABCD_0000_0000;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(resp_load == 0, "R8 read not served by stale byte", 64'(resp_load), 0);
    rx_valid = 1'b1; rx_data = 8'h21;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(resp_word == rsp(16'h0100, 16'h0121), "R6 R8 fresh byte",
        resp_word, rsp(16'h0100, 16'h0121));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule